// File: doc/BRIEF.md
# Set Lookup and Age-Based Replacement

This block holds the tag state of one set of a set-associative cache bank and serves one core access at a time. Each way keeps a valid bit, a dirty bit, a stored tag and a small saturating age counter. An access compares its tag against every valid way, ages the ways and reports, one cycle later, either the hitting way or the way chosen for replacement. An upstream miss tracker records that way and later issues a fill, which installs the new tag.

Write hits follow the selected policy. In write-through mode a write hit sends a memory write at once. In write-back mode it marks the line dirty, and a later miss that must replace a dirty line sends that line's address out as a writeback. A clear command wipes the whole set. Data storage and memory timing are outside this block.

Top module: `set_lookup`

## Requirements
- R1: After reset `rsp_valid` and `wb_valid` are 0 and every way is invalid, so the first access misses and reports way WAYS-1.
- R2: An accepted access gives `rsp_valid`=1 in the next cycle. If a valid way holds the same tag, the response has `rsp_hit`=1 and `rsp_way` set to that way. In any cycle with no accepted access, `rsp_valid` is 0.
- R3: On every accepted access, the counter of the hitting way becomes 0 and the counter of every other valid way grows by one. A counter at its maximum (2^CNT_W-1) stays there. Invalid ways keep their counters.
- R4: On a miss, `rsp_way` is the highest-indexed invalid way if there is one. Otherwise it is the valid way with the largest counter after the update, and the lowest index wins a tie.
- R5: A write hit in write-through mode (`wt_mode`=1) pulses `wb_valid` with `wb_addr` = {stored tag, `set_id`, `bank_id`}: the tag in the high bits and the bank in the low bits. The line is not marked dirty.
- R6: A write hit in write-back mode (`wt_mode`=0) marks the line dirty and raises no `wb_valid`.
- R7: A miss in write-back mode with no invalid way, whose victim is dirty, pulses `wb_valid` with the victim's address in the layout of R5. A clean victim, a free way or write-through mode gives no writeback. A miss changes no valid, dirty or tag state.
- R8: A fill makes way `fill_way` valid with tag `fill_tag`, clears its dirty bit and sets its counter to 0. A fill produces no response and no writeback.
- R9: A clear makes every way invalid and clean and sets every counter to 0.
- R10: Clear takes priority over fill, and fill over access. A request of lower priority in the same cycle is dropped and gets no response.
- R11: `wb_valid` is high only in the response cycle of the access that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wt_mode | input | 1 | 1 selects write-through, 0 selects write-back |
| bank_id | input | BANK_W | Bank number used to rebuild addresses |
| set_id | input | SET_W | Set number used to rebuild addresses |
| clr_req | input | 1 | Clear the whole set |
| fill_req | input | 1 | Install a tag into one way |
| fill_way | input | WAY_W | Way to install into |
| fill_tag | input | TAG_W | Tag to install |
| acc_req | input | 1 | Core access request |
| acc_write | input | 1 | Access is a write |
| acc_tag | input | TAG_W | Access tag |
| rsp_valid | output | 1 | Response for last cycle's access |
| rsp_hit | output | 1 | Access hit |
| rsp_way | output | WAY_W | Hit way, or victim way on a miss |
| wb_valid | output | 1 | Memory write request |
| wb_addr | output | TAG_W+SET_W+BANK_W | Memory write line address |

## Verification
A corrupted tag or valid bit shows up at the next access to the affected tag, either as a false hit or a false miss, or as a changed victim in `rsp_way`. A counter that wraps instead of saturating, or that ages the wrong ways, stays hidden until a full set misses, and then it moves `rsp_way`. A lost or spurious dirty bit shows up only when that line is evicted in write-back mode, as a missing or extra `wb_valid`. The random mix therefore repeats tags from a small pool against a full set, so that many misses land on aged, dirty ways soon after the faulty update.

// File: rtl/set_lookup_pkg.sv
package set_lookup_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_CLEAR  = 2'd1,
    OP_FILL   = 2'd2,
    OP_ACCESS = 2'd3
  } set_op_e;
endpackage

// File: rtl/way_state.sv
module way_state
  import set_lookup_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  set_op_e          op,
  input  logic             fill_sel,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [TAG_W-1:0] acc_tag,
  input  logic             acc_write,
  input  logic             wt_mode,
  output logic             valid,
  output logic             dirty,
  output logic [TAG_W-1:0] tag,
  output logic             hit,
  output logic [CNT_W-1:0] cnt_upd
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             valid_q, valid_d;
  logic             dirty_q, dirty_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign hit = valid_q && (tag_q == acc_tag);

  always_comb begin
    if (hit)                  cnt_upd = '0;
    else if (!valid_q)        cnt_upd = cnt_q;
    else if (cnt_q == CNT_MAX) cnt_upd = cnt_q;
    else                      cnt_upd = cnt_q + 1'b1;
  end

  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    tag_d   = tag_q;
    cnt_d   = cnt_q;
    unique case (op)
      OP_CLEAR: begin
        valid_d = 1'b0;
        dirty_d = 1'b0;
        cnt_d   = '0;
      end
      OP_FILL: if (fill_sel) begin
        valid_d = 1'b1;
        dirty_d = 1'b0;
        tag_d   = fill_tag;
        cnt_d   = '0;
      end
      OP_ACCESS: begin
        cnt_d = cnt_upd;
        if (hit && acc_write && !wt_mode) dirty_d = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      dirty_q <= 1'b0;
      tag_q   <= '0;
      cnt_q   <= '0;
    end else begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
      tag_q   <= tag_d;
      cnt_q   <= cnt_d;
    end
  end

  assign valid = valid_q;
  assign dirty = dirty_q;
  assign tag   = tag_q;

  // R3: a nonzero counter has only held or grown since the last edge
  p_cnt_mono_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (cnt_q >= $past(cnt_q)));
  // R8: a fill leaves the selected way valid and clean
  p_fill_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_FILL && fill_sel) |=> (valid_q && !dirty_q && cnt_q == '0));
endmodule

// File: rtl/victim_pick.sv
module victim_pick #(
  parameter int WAYS  = 4,
  parameter int CNT_W = 3,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]  valid,
  input  logic [CNT_W-1:0] cnt [WAYS],
  output logic             any_free,
  output logic [WAY_W-1:0] victim
);
  logic [CNT_W-1:0] best;
  logic [WAY_W-1:0] oldest;
  logic [WAY_W-1:0] free_way;

  always_comb begin
    any_free = 1'b0;
    free_way = '0;
    best     = '0;
    oldest   = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (!valid[i]) begin
        any_free = 1'b1;
        free_way = WAY_W'(i);
      end else if (cnt[i] > best) begin
        best   = cnt[i];
        oldest = WAY_W'(i);
      end
    end
    victim = any_free ? free_way : oldest;
  end

  // R4: a free way is always preferred over a valid one
  always_comb begin
    if (any_free) p_free_first_r4: assert (!valid[victim]);
  end
endmodule

// File: rtl/set_lookup.sv
module set_lookup
  import set_lookup_pkg::*;
#(
  parameter int WAYS   = 4,
  parameter int TAG_W  = 8,
  parameter int CNT_W  = 3,
  parameter int SET_W  = 4,
  parameter int BANK_W = 2,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int ADDR_W = TAG_W + SET_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wt_mode,
  input  logic [BANK_W-1:0] bank_id,
  input  logic [SET_W-1:0]  set_id,
  input  logic              clr_req,
  input  logic              fill_req,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic              acc_req,
  input  logic              acc_write,
  input  logic [TAG_W-1:0]  acc_tag,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr
);
  set_op_e          op;
  logic [WAYS-1:0]  way_valid, way_dirty, way_hit;
  logic [TAG_W-1:0] way_tag [WAYS];
  logic [CNT_W-1:0] way_cnt [WAYS];
  logic             any_free, any_hit;
  logic [WAY_W-1:0] victim, hit_way, sel_way;
  logic             wb_d;
  logic [TAG_W-1:0] wb_tag_d;

  always_comb begin
    if (clr_req)       op = OP_CLEAR;
    else if (fill_req) op = OP_FILL;
    else if (acc_req)  op = OP_ACCESS;
    else               op = OP_NONE;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    way_state #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_way (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .fill_sel  (fill_way == WAY_W'(w)),
      .fill_tag  (fill_tag),
      .acc_tag   (acc_tag),
      .acc_write (acc_write),
      .wt_mode   (wt_mode),
      .valid     (way_valid[w]),
      .dirty     (way_dirty[w]),
      .tag       (way_tag[w]),
      .hit       (way_hit[w]),
      .cnt_upd   (way_cnt[w])
    );
  end

  victim_pick #(.WAYS(WAYS), .CNT_W(CNT_W), .WAY_W(WAY_W)) u_pick (
    .valid    (way_valid),
    .cnt      (way_cnt),
    .any_free (any_free),
    .victim   (victim)
  );

  always_comb begin
    hit_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (way_hit[i]) hit_way = WAY_W'(i);
    end
  end

  assign any_hit = |way_hit;
  assign sel_way = any_hit ? hit_way : victim;

  always_comb begin
    wb_d     = 1'b0;
    wb_tag_d = way_tag[sel_way];
    if (op == OP_ACCESS) begin
      if (any_hit) wb_d = acc_write && wt_mode;
      else         wb_d = !wt_mode && !any_free && way_dirty[victim];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_way   <= '0;
      wb_valid  <= 1'b0;
      wb_addr   <= '0;
    end else begin
      rsp_valid <= (op == OP_ACCESS);
      wb_valid  <= wb_d;
      if (op == OP_ACCESS) begin
        rsp_hit <= any_hit;
        rsp_way <= sel_way;
      end
      if (wb_d) wb_addr <= {wb_tag_d, set_id, bank_id};
    end
  end

  // R2: at most one way may match a tag
  p_onehot_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ACCESS) |-> $onehot0(way_hit));
  // R10: lower-priority requests in a clear or fill cycle get no response
  p_drop_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req || fill_req) |=> !rsp_valid);
  // R11: a writeback only appears with an access response
  p_wb_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> rsp_valid);
  // R7: an eviction writeback only in write-back mode
  p_evict_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !rsp_hit) |-> !$past(wt_mode));
endmodule

// File: tb/set_lookup_test.sv
`timescale 1ns/1ps
module set_lookup_test;
  localparam int WAYS = 4, TAG_W = 8, CNT_W = 3, SET_W = 4, BANK_W = 2;
  localparam int WAY_W = 2, ADDR_W = TAG_W + SET_W + BANK_W;
  localparam int CMAX = 7;

  logic clk = 0, rst_n = 0;
  logic wt_mode = 0, clr_req = 0, fill_req = 0, acc_req = 0, acc_write = 0;
  logic [BANK_W-1:0] bank_id = 2'd1;
  logic [SET_W-1:0]  set_id  = 4'h5;
  logic [WAY_W-1:0]  fill_way = '0;
  logic [TAG_W-1:0]  fill_tag = '0, acc_tag = '0;
  logic rsp_valid, rsp_hit, wb_valid;
  logic [WAY_W-1:0]  rsp_way;
  logic [ADDR_W-1:0] wb_addr;

  always #5 clk = ~clk;

  set_lookup uut (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  bit m_v [WAYS];
  bit m_d [WAYS];
  int m_t [WAYS];
  int m_c [WAYS];

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < WAYS; i++) begin m_v[i] = 0; m_d[i] = 0; m_c[i] = 0; end
  endtask

  task automatic model_access(input bit wr, input int t, input bit wt,
                              output bit hit, output int way, output bit wbv, output int wba);
    int free_w, best;
    hit = 0; way = 0; wbv = 0; wba = 0; free_w = -1; best = 0;
    for (int i = 0; i < WAYS; i++) begin
      if (m_v[i] && m_t[i] == t) begin hit = 1; way = i; m_c[i] = 0; end
      else if (m_v[i] && m_c[i] < CMAX) m_c[i]++;
    end
    if (hit) begin
      if (wr && wt) begin wbv = 1; wba = (m_t[way] << 6) | (5 << 2) | 1; end
      else if (wr) m_d[way] = 1;
    end else begin
      for (int i = 0; i < WAYS; i++) if (!m_v[i]) free_w = i;
      if (free_w >= 0) way = free_w;
      else for (int i = 0; i < WAYS; i++) if (m_c[i] > best) begin best = m_c[i]; way = i; end
      if (!wt && free_w < 0 && m_d[way]) begin wbv = 1; wba = (m_t[way] << 6) | (5 << 2) | 1; end
    end
  endtask

  // drive at a negedge, check at the next negedge
  task automatic do_access(string req, bit wr, int t, bit wt, output int way);
    bit eh, ewb; int ea;
    acc_req = 1; acc_write = wr; acc_tag = TAG_W'(t); wt_mode = wt;
    model_access(wr, t, wt, eh, way, ewb, ea);
    @(negedge clk);
    acc_req = 0;
    check({req, " rsp_valid"}, rsp_valid, 1);
    check({req, " hit"}, rsp_hit, eh);
    check({req, " way"}, rsp_way, way);
    check({req, " wb_valid"}, wb_valid, ewb);
    if (ewb) check({req, " wb_addr"}, wb_addr, ea);
  endtask

  task automatic do_fill(int w, int t);
    fill_req = 1; fill_way = WAY_W'(w); fill_tag = TAG_W'(t);
    @(negedge clk);
    fill_req = 0;
    m_v[w] = 1; m_d[w] = 0; m_t[w] = t; m_c[w] = 0;
    check("R8 fill no rsp", rsp_valid, 0);
    check("R8 fill no wb", wb_valid, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int w;
    void'($urandom(32'd11));
    model_clear();
    repeat (3) @(negedge clk);
    check("R1 reset rsp_valid", rsp_valid, 0);
    check("R1 reset wb_valid", wb_valid, 0);
    rst_n = 1;
    @(negedge clk);
    check("R2 idle no rsp", rsp_valid, 0);
    do_access("R1 first miss", 0, 8'h10, 0, w);
    check("R1 victim top way", w, WAYS - 1);
    // fill all ways, directed hits
    for (int i = 0; i < WAYS; i++) do_fill(i, 8'h20 + i);
    do_access("R2 hit way2", 0, 8'h22, 0, w);
    // R3 saturation: hit way0 repeatedly, others saturate
    for (int k = 0; k < 10; k++) do_access("R3 age", 0, 8'h20, 0, w);
    do_access("R4 tie lowest", 0, 8'h99, 0, w);
    check("R3 R4 saturated tie victim", w, 1);
    // R6 write hit write-back then R7 eviction of dirty line
    do_access("R6 wb write hit", 1, 8'h21, 0, w);
    check("R6 no wb", wb_valid, 0);
    for (int k = 0; k < 10; k++) do_access("R3 age2", 0, 8'h20, 0, w);
    do_access("R7 dirty evict", 0, 8'h77, 0, w);
    // R5 write-through hit
    do_access("R5 wt write hit", 1, 8'h23, 1, w);
    check("R5 wb addr", wb_addr, (8'h23 << 6) | (5 << 2) | 1);
    // R11 pulse ends
    @(negedge clk);
    check("R11 wb pulse end", wb_valid, 0);
    // R10 clear + fill + access same cycle
    clr_req = 1; fill_req = 1; acc_req = 1; acc_tag = 8'h20; fill_way = 0; fill_tag = 8'h55;
    @(negedge clk);
    clr_req = 0; fill_req = 0; acc_req = 0;
    model_clear();
    check("R10 clear drops access", rsp_valid, 0);
    do_access("R9 cleared miss", 0, 8'h20, 0, w);
    check("R9 cleared victim", w, WAYS - 1);
    // R10 fill beats access
    fill_req = 1; acc_req = 1; fill_way = 1; fill_tag = 8'h44; acc_tag = 8'h44;
    @(negedge clk);
    fill_req = 0; acc_req = 0;
    m_v[1] = 1; m_d[1] = 0; m_t[1] = 8'h44; m_c[1] = 0;
    check("R10 fill drops access", rsp_valid, 0);
    do_access("R8 filled hit", 0, 8'h44, 0, w);
    // random mix
    for (int n = 0; n < 600; n++) begin
      int r, t, hw;
      r = $urandom % 16;
      t = 8'h30 + ($urandom % 7);
      if (r == 0) begin
        clr_req = 1; @(negedge clk); clr_req = 0; model_clear();
        check("R9 clear no rsp", rsp_valid, 0);
      end else begin
        bit h;
        h = 0;
        for (int i = 0; i < WAYS; i++) if (m_v[i] && m_t[i] == t) h = 1;
        do_access("R2 R3 R4 R5 R6 R7 random", $urandom % 2, t, ($urandom % 4) == 0, hw);
        if (!h && ($urandom % 3) != 0) do_fill(hw, t);
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule